// File: doc/BRIEF.md
# ULPI Link Startup Sequencer

This block sits on the link side of a ULPI connection and takes a freshly powered PHY to the point where USB traffic may begin. After power-up the PHY owns the bus (DIR high) until its clock is stable. Once it first lets go of the bus, the block writes the reset bit of the PHY's Function Control register through a standard register-write command. It then waits for the PHY to take the bus again and release it, which marks the end of the PHY's internal reset, and raises a ready flag once the bus has been quiet for a full cycle.

Receive commands that the PHY presents before that point are stale and are discarded. After ready, the block passes each receive command byte on through a one-cycle report strobe. If the PHY does not complete the reset handshake within a bounded number of cycles, the block raises a sticky error and retries the write once. If the second attempt also times out, it parks in a failed state.

Top module: `ulpi_link_startup`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ulpi_data_oe`, `ulpi_stp`, `link_ready`, `startup_err` and `rxcmd_valid` are 0 and `ulpi_data_o` is 0x00.
- R2: `ulpi_data_oe` in any cycle equals the inverse of `ulpi_dir` sampled at the preceding clock edge, so the link never drives the bus while the PHY has held DIR high for two edges.
- R3: Outside the command and data phases of the register write, `ulpi_data_o` is 0x00.
- R4: After the first DIR fall that follows a DIR high, the block drives the command byte 0x84 (bits 7:6 = 2'b10 for a register write, bits 5:0 = Function Control address 0x04) until NXT is sampled high. It then drives 0x20 (bit 5 = reset) until NXT is sampled high, and then asserts `ulpi_stp` for exactly one cycle with data 0x00.
- R5: No receive command is reported (`rxcmd_valid` stays 0) before `link_ready` is 1, whatever the PHY presents on the bus.
- R6: After the stop cycle, a DIR rise followed by a DIR fall completes the handshake. `link_ready` rises one cycle after the first edge that samples DIR low, provided the next edge samples DIR low as well.
- R7: If the handshake is not complete TIMEOUT_CYCLES+1 edges after the stop cycle, `startup_err` rises and the 0x84 command is driven again in that same cycle.
- R8: After a second timeout, the block stays not ready, keeps `startup_err` high and drives no further command bytes.
- R9: Once ready, an edge that samples DIR high, with DIR also high at the edge before it and NXT low, produces `rxcmd_valid` = 1 for one cycle, with `rxcmd_data` equal to the sampled bus byte. A DIR turnaround edge or NXT high produces no report.
- R10: `startup_err` and `link_ready` never fall again once raised, until reset.
- R11: If DIR goes high during the data phase of the write, the write restarts from the command byte after DIR falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ULPI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ulpi_dir | input | 1 | Bus direction from the PHY (1 = PHY drives) |
| ulpi_nxt | input | 1 | PHY throttle / accept strobe |
| ulpi_data_i | input | 8 | Bus data from the PHY |
| ulpi_data_o | output | 8 | Bus data from the link |
| ulpi_data_oe | output | 1 | Link output enable for the data bus |
| ulpi_stp | output | 1 | Stop strobe ending the register write |
| link_ready | output | 1 | PHY reset finished; bus usable |
| startup_err | output | 1 | Sticky: a reset handshake timed out |
| rxcmd_valid | output | 1 | One-cycle report of a receive command |
| rxcmd_data | output | 8 | Reported receive command byte |

## Verification
The bench plays the PHY and floods the bus with bogus receive commands during power-up, during the command phase and during the PHY reset. A block that forwarded stale status would raise `rxcmd_valid` before ready. Timeouts are checked to the exact cycle on both sides, so a counter that is off by one fires either one check early or one check late. The bench also checks that a second timeout gives up rather than looping forever. It aborts the data phase with a DIR rise to catch a design that finishes a write the PHY never accepted. After ready it sweeps byte values through the receive path and inserts turnaround and NXT-high cycles, which a design that ignored turnaround would report as data.

// File: rtl/ulpi_startup_pkg.sv
package ulpi_startup_pkg;
    localparam int unsigned BUS_W       = 8;
    localparam int unsigned ADDR_W      = 6;
    localparam logic [1:0]  CMD_REGWR   = 2'b10;
    localparam logic [5:0]  FUNC_CTRL_A = 6'h04;
    localparam int unsigned RESET_BIT   = 5;

    typedef enum logic [3:0] {
        ST_POWERUP, ST_PHY_OWN, ST_CMD, ST_DATA, ST_STOP,
        ST_WAIT_HI, ST_WAIT_LO, ST_SETTLE, ST_READY, ST_FAILED
    } seq_state_e;

    typedef struct packed {
        seq_state_e        state;
        logic              retried;
        logic              err;
        logic              rx_vld;
        logic [BUS_W-1:0]  rx_byte;
    } seq_regs_t;
endpackage

// File: rtl/ulpi_bus_turn.sv
module ulpi_bus_turn (
    input  logic clk,
    input  logic rst_n,
    input  logic dir,
    output logic dir_prev,
    output logic oe
);
    typedef struct packed {
        logic dir_prev;
        logic oe;
    } turn_t;

    turn_t turn_d, turn_q;

    always_comb begin
        turn_d          = turn_q;
        turn_d.dir_prev = dir;
        turn_d.oe       = ~dir;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) turn_q <= '{dir_prev: 1'b1, oe: 1'b0};
        else        turn_q <= turn_d;
    end

    assign dir_prev = turn_q.dir_prev;
    assign oe       = turn_q.oe;

    // R2
    no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir && $past(dir)) |-> !oe);
endmodule

// File: rtl/ulpi_wait_timer.sv
module ulpi_wait_timer #(
    parameter int unsigned LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int unsigned CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)              cnt_d = '0;
        else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == LAST);

    // R7
    cnt_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> cnt_q == '0);
endmodule

// File: rtl/ulpi_startup_fsm.sv
module ulpi_startup_fsm
    import ulpi_startup_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir,
    input  logic             dir_prev,
    input  logic             nxt,
    input  logic [BUS_W-1:0] data_i,
    input  logic             expired,
    output logic             timer_run,
    output logic [BUS_W-1:0] data_o,
    output logic             stp,
    output logic             ready,
    output logic             err,
    output logic             rx_vld,
    output logic [BUS_W-1:0] rx_byte
);
    localparam logic [BUS_W-1:0] CMD_BYTE  = {CMD_REGWR, FUNC_CTRL_A};
    localparam logic [BUS_W-1:0] DATA_BYTE = BUS_W'(1) << RESET_BIT;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.rx_vld = 1'b0;
        unique case (r_q.state)
            ST_POWERUP: if (dir)  r_d.state = ST_PHY_OWN;
            ST_PHY_OWN: if (!dir) r_d.state = ST_CMD;
            ST_CMD:     if (!dir && nxt) r_d.state = ST_DATA;
            ST_DATA: begin
                if (dir)      r_d.state = ST_CMD;
                else if (nxt) r_d.state = ST_STOP;
            end
            ST_STOP:    r_d.state = ST_WAIT_HI;
            ST_WAIT_HI, ST_WAIT_LO: begin
                if (r_q.state == ST_WAIT_HI && dir)       r_d.state = ST_WAIT_LO;
                else if (r_q.state == ST_WAIT_LO && !dir) r_d.state = ST_SETTLE;
                else if (expired) begin
                    r_d.err     = 1'b1;
                    r_d.retried = 1'b1;
                    r_d.state   = r_q.retried ? ST_FAILED : ST_CMD;
                end
            end
            ST_SETTLE:  r_d.state = dir ? ST_WAIT_LO : ST_READY;
            ST_READY: begin
                if (dir && dir_prev && !nxt) begin
                    r_d.rx_vld  = 1'b1;
                    r_d.rx_byte = data_i;
                end
            end
            ST_FAILED:  r_d.state = ST_FAILED;
            default:    r_d.state = ST_POWERUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{state: ST_POWERUP, retried: 1'b0, err: 1'b0,
                             rx_vld: 1'b0, rx_byte: '0};
        else        r_q <= r_d;
    end

    assign timer_run = (r_q.state == ST_WAIT_HI) || (r_q.state == ST_WAIT_LO)
                    || (r_q.state == ST_SETTLE);
    assign data_o    = (r_q.state == ST_CMD)  ? CMD_BYTE  :
                       (r_q.state == ST_DATA) ? DATA_BYTE : '0;
    assign stp       = (r_q.state == ST_STOP);
    assign ready     = (r_q.state == ST_READY);
    assign err       = r_q.err;
    assign rx_vld    = r_q.rx_vld;
    assign rx_byte   = r_q.rx_byte;

    // R4
    stp_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stp |=> !stp);
    // R5
    rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld |-> ready);
    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    // R10
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
endmodule

// File: rtl/ulpi_link_startup.sv
module ulpi_link_startup
    import ulpi_startup_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ulpi_dir,
    input  logic       ulpi_nxt,
    input  logic [7:0] ulpi_data_i,
    output logic [7:0] ulpi_data_o,
    output logic       ulpi_data_oe,
    output logic       ulpi_stp,
    output logic       link_ready,
    output logic       startup_err,
    output logic       rxcmd_valid,
    output logic [7:0] rxcmd_data
);
    logic dir_prev, timer_run, expired;

    ulpi_bus_turn u_turn (
        .clk(clk), .rst_n(rst_n), .dir(ulpi_dir),
        .dir_prev(dir_prev), .oe(ulpi_data_oe)
    );

    ulpi_wait_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(timer_run), .expired(expired)
    );

    ulpi_startup_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .dir(ulpi_dir), .dir_prev(dir_prev),
        .nxt(ulpi_nxt), .data_i(ulpi_data_i), .expired(expired),
        .timer_run(timer_run), .data_o(ulpi_data_o), .stp(ulpi_stp),
        .ready(link_ready), .err(startup_err), .rx_vld(rxcmd_valid),
        .rx_byte(rxcmd_data)
    );

    // R6
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_ready) |-> (!$past(ulpi_dir) && !$past(ulpi_dir, 2)));
    // R3
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ulpi_stp || link_ready) |-> ulpi_data_o == 8'h00);
endmodule

// File: tb/ulpi_link_startup_bench.sv
module ulpi_link_startup_bench;
    localparam int unsigned TMO = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir = 1'b1, nxt = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout, rxd;
    logic       oe, stp, rdy, err, rxv;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    ulpi_link_startup #(.TIMEOUT_CYCLES(TMO)) u_ulpi_link_startup (
        .clk(clk), .rst_n(rst_n), .ulpi_dir(dir), .ulpi_nxt(nxt),
        .ulpi_data_i(din), .ulpi_data_o(dout), .ulpi_data_oe(oe),
        .ulpi_stp(stp), .link_ready(rdy), .startup_err(err),
        .rxcmd_valid(rxv), .rxcmd_data(rxd)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // PHY holds the bus with bogus status; nothing may be reported before ready
    task automatic phy_busy(input int cycles, input logic [7:0] seed);
        for (int i = 0; i < cycles; i++) begin
            dir = 1'b1; nxt = 1'b0; din = seed + 8'(i * 37);
            step();
            chk(rxv == 1'b0, "R5", rxv, 0);
            if (i > 0) chk(oe == 1'b0, "R2", oe, 0);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; dir = 1'b1; nxt = 1'b0; din = 8'h00;
        repeat (3) step();
        chk({oe, stp, rdy, err, rxv} == 5'b0 && dout == 8'h00, "R1", {oe, stp, rdy, err, rxv, dout}, 0);
        rst_n = 1'b1;
        step();
        chk({oe, stp, rdy, err, rxv} == 5'b0 && dout == 8'h00, "R1", {oe, stp, rdy, err, rxv, dout}, 0);
    endtask

    // release bus, accept cmd and data bytes, observe stop
    task automatic run_write(input int cmd_wait);
        dir = 1'b0; nxt = 1'b0;
        step();
        chk(oe == 1'b1, "R2", oe, 1);
        for (int i = 0; i < cmd_wait; i++) begin
            chk(dout == 8'h84 && !stp, "R4", dout, 8'h84);
            step();
        end
        chk(dout == 8'h84, "R4", dout, 8'h84);
        nxt = 1'b1; step();
        chk(dout == 8'h20, "R4", dout, 8'h20);
        step();
        chk(stp == 1'b1 && dout == 8'h00, "R4", {stp, dout}, 9'h100);
        nxt = 1'b0;
    endtask

    task automatic phy_reset_done();
        phy_busy(4, 8'h3C);
        dir = 1'b0; step();
        chk(rdy == 1'b0, "R6", rdy, 0);
        step();
        chk(rdy == 1'b1, "R6", rdy, 1);
    endtask

    initial begin
        // scenario A: clean start with abort of the data phase
        do_reset();
        phy_busy(6, 8'h11);
        dir = 1'b0; step();
        chk(dout == 8'h84 && oe, "R4", dout, 8'h84);
        nxt = 1'b1; step();
        chk(dout == 8'h20, "R4", dout, 8'h20);
        nxt = 1'b0;
        phy_busy(3, 8'hA1);
        dir = 1'b0; step();
        chk(dout == 8'h84, "R11", dout, 8'h84);
        run_write(2);
        step();
        chk(stp == 1'b0 && dout == 8'h00, "R3", {stp, dout}, 0);
        phy_reset_done();
        chk(err == 1'b0, "R10", err, 0);
        // receive path sweep after ready
        dir = 1'b1; din = 8'hFF; step();
        chk(rxv == 1'b0, "R9", rxv, 0);
        for (int v = 0; v < 256; v += 17) begin
            din = 8'(v); nxt = 1'b0; step();
            chk(rxv == 1'b1 && rxd == 8'(v), "R9", {rxv, rxd}, {1'b1, 8'(v)});
            nxt = 1'b1; step();
            chk(rxv == 1'b0, "R9", rxv, 0);
        end
        dir = 1'b0; nxt = 1'b0; step();
        chk(rxv == 1'b0 && rdy, "R10", {rdy, rxv}, 2);

        // scenario B: one timeout then success
        do_reset();
        phy_busy(2, 8'h55);
        run_write(0);
        for (int i = 1; i <= TMO + 1; i++) begin
            step();
            if (i == TMO)     chk(err == 1'b0, "R7", err, 0);
            if (i == TMO + 1) chk(err == 1'b1 && dout == 8'h84, "R7", {err, dout}, 9'h184);
        end
        nxt = 1'b1; step();
        chk(dout == 8'h20, "R7", dout, 8'h20);
        step();
        chk(stp == 1'b1, "R7", stp, 1);
        nxt = 1'b0;
        phy_reset_done();
        chk(err == 1'b1, "R10", err, 1);

        // scenario C: two timeouts, then give up
        do_reset();
        phy_busy(2, 8'h77);
        run_write(1);
        for (int i = 0; i < TMO + 1; i++) step();
        chk(err == 1'b1 && dout == 8'h84, "R7", {err, dout}, 9'h184);
        nxt = 1'b1; step(); step();
        chk(stp == 1'b1, "R8", stp, 1);
        for (int i = 0; i < 3 * TMO; i++) begin
            nxt = 1'(i & 1); step();
            if (i > TMO + 2) chk(dout == 8'h00 && !rdy && err && !stp, "R8", {rdy, err, stp, dout}, 11'h200);
        end
        phy_busy(4, 8'h90);
        dir = 1'b0; repeat (3) step();
        chk(!rdy && err, "R8", {rdy, err}, 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule